// File: doc/BRIEF.md
# Idle Tick Timer

This block is a free-running 16-bit down counter that advances once per instruction-cycle tick. Software cannot read or load it, and reset does not clear it. Its only visible effect is a periodic event: whenever count bit 12 changes value, which happens once every 4096 ticks, the block latches a pending flag. Software can set and clear that flag. An enable flag decides whether the pending flag drives the interrupt line.

The same periodic event does two more jobs. While the device sits in its idle low-power state, the event produces a one-cycle wake pulse, whether or not the interrupt is enabled. After a halt wake-up request, the block holds its start-up-done output low until the next event, then pulses it for one cycle. This gives a fixed oscillator settling delay without a second counter.

Top module: `idle_tick_timer`

## Requirements
- R1: The counter decreases by exactly one on each cycle where `tick` is high and holds otherwise; no port loads, clears or reads it, and reset leaves it running.
- R2: `pnd` is set by every change of count bit 12, so with the flag cleared between events it rises exactly 4096 ticks after the previous rise, however the ticks are spaced in time.
- R3: While and directly after reset, `pnd`, `ien`, `irq`, `wake` and `startup_done` are all 0.
- R4: A write on `ien_wr` loads `ien_wdata` into `ien` at the next edge; `irq` is high exactly when both `ien` and `pnd` are 1.
- R5: A write on `pnd_wr` with `pnd_wdata` = 0 clears `pnd` at the next edge, and with `pnd_wdata` = 1 sets it.
- R6: When a bit-12 change and a clearing write of `pnd` land on the same edge, `pnd` ends up 1.
- R7: After a `halt_exit` request, `startup_done` stays 0 until the next bit-12 change and then is 1 for exactly one cycle; a request on the same edge as a change waits for the change after it.
- R8: While `idle_mode` is 1, each bit-12 change gives a one-cycle pulse on `wake`, regardless of `ien`; with `idle_mode` 0, `wake` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for flags and sequencing (not the counter) |
| tick | input | 1 | Instruction-cycle tick; the counter steps on cycles where it is high |
| ien_wr | input | 1 | Write strobe for the interrupt enable flag |
| ien_wdata | input | 1 | Value written to the enable flag |
| pnd_wr | input | 1 | Write strobe for the pending flag |
| pnd_wdata | input | 1 | Value written to the pending flag |
| idle_mode | input | 1 | High while the device is in the idle low-power state |
| halt_exit | input | 1 | One-cycle request starting the post-halt start-up delay |
| ien | output | 1 | Current interrupt enable flag |
| pnd | output | 1 | Current pending flag |
| irq | output | 1 | Interrupt request, enable and pending both set |
| wake | output | 1 | One-cycle idle-exit pulse on each bit-12 change while idle |
| startup_done | output | 1 | One-cycle pulse ending the start-up delay |

## Verification
Two collisions matter most. The first is a software clear of the pending flag on the same edge as a bit-12 change. The second is a halt-exit request on the same edge as a change. The bench keeps its own count of ticks since the last event, synchronised to the first observed flag rise. It uses that count to place a clearing write, or a request, exactly on an event edge. It then expects the flag to remain set and the start-up pulse to slip to the following event. Every cycle, a behavioural model that counts ticks is compared against all five outputs.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;

   typedef enum logic {
      SU_OFF   = 1'b0,
      SU_ARMED = 1'b1
   } su_state_t;

   localparam int unsigned DEF_CNT_W   = 16;
   localparam int unsigned DEF_TAP_BIT = 12;

endpackage

// File: rtl/idle_tmr_count.sv
module idle_tmr_count #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned TAP_BIT    = 12,
   parameter bit          TICK_GATED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic tap_tog
);

   localparam int unsigned LOW_W = TAP_BIT;

   logic             step;
   logic [CNT_W-1:0] cnt;

   generate
      if (TICK_GATED) begin : g_gated
         assign step = tick;
      end else begin : g_every_clk
         assign step = 1'b1;
      end
   endgenerate

   // No reset: the count starts from whatever value the flops hold.
   always_ff @(posedge clk) begin
      if (step) cnt <= cnt - CNT_W'(1);
   end

   // The tap bit changes on the step that wraps the bits below it.
   assign tap_tog = step && (cnt[LOW_W-1:0] == '0);

   p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cnt == $past(cnt) - CNT_W'(1)));

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt));

   p_tap_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tap_tog |=> (cnt[TAP_BIT] != $past(cnt[TAP_BIT])));

   p_tap_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tap_tog |=> (cnt[TAP_BIT] == $past(cnt[TAP_BIT])));

endmodule

// File: rtl/idle_tmr_flags.sv
module idle_tmr_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic tog,
   input  logic en_wr,
   input  logic en_wd,
   input  logic pnd_wr,
   input  logic pnd_wd,
   output logic en_q,
   output logic pnd_q,
   output logic irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         pnd_q <= 1'b0;
      end else begin
         if (en_wr) en_q <= en_wd;
         if (tog)         pnd_q <= 1'b1;
         else if (pnd_wr) pnd_q <= pnd_wd;
      end
   end

   assign irq = en_q & pnd_q;

   p_tog_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tog |=> pnd_q);

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pnd_wr && !pnd_wd && !tog) |=> !pnd_q);

   p_en_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> (en_q == $past(en_wd)));

endmodule

// File: rtl/idle_tmr_wake.sv
module idle_tmr_wake
   import idle_tmr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tog,
   input  logic idle_mode,
   input  logic halt_exit,
   output logic wake,
   output logic startup_done
);

   su_state_t su_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         su_q         <= SU_OFF;
         wake         <= 1'b0;
         startup_done <= 1'b0;
      end else begin
         wake         <= tog & idle_mode;
         startup_done <= (su_q == SU_ARMED) & tog;
         if (halt_exit)   su_q <= SU_ARMED;
         else if (tog)    su_q <= SU_OFF;
      end
   end

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      startup_done |=> !startup_done);

   p_done_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      startup_done |-> $past(su_q == SU_ARMED));

   p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !wake);

   p_wake_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(idle_mode));

endmodule

// File: rtl/idle_tick_timer.sv
module idle_tick_timer #(
   parameter int unsigned CNT_W      = idle_tmr_pkg::DEF_CNT_W,
   parameter int unsigned TAP_BIT    = idle_tmr_pkg::DEF_TAP_BIT,
   parameter bit          TICK_GATED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic ien_wr,
   input  logic ien_wdata,
   input  logic pnd_wr,
   input  logic pnd_wdata,
   input  logic idle_mode,
   input  logic halt_exit,
   output logic ien,
   output logic pnd,
   output logic irq,
   output logic wake,
   output logic startup_done
);

   generate
      if (TAP_BIT < 1 || TAP_BIT >= CNT_W) begin : g_bad_tap
         $error("idle_tick_timer: TAP_BIT must lie in 1..CNT_W-1");
      end
   endgenerate

   logic tap_tog;

   idle_tmr_count #(
      .CNT_W      (CNT_W),
      .TAP_BIT    (TAP_BIT),
      .TICK_GATED (TICK_GATED)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .tap_tog (tap_tog)
   );

   idle_tmr_flags u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .tog    (tap_tog),
      .en_wr  (ien_wr),
      .en_wd  (ien_wdata),
      .pnd_wr (pnd_wr),
      .pnd_wd (pnd_wdata),
      .en_q   (ien),
      .pnd_q  (pnd),
      .irq    (irq)
   );

   idle_tmr_wake u_wake (
      .clk          (clk),
      .rst_n        (rst_n),
      .tog          (tap_tog),
      .idle_mode    (idle_mode),
      .halt_exit    (halt_exit),
      .wake         (wake),
      .startup_done (startup_done)
   );

   p_reset_quiet_r3: assert property (@(posedge clk)
      !rst_n |=> (!pnd && !ien && !wake && !startup_done));

   p_no_irq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ien) |-> !irq);

endmodule

// File: tb/idle_tick_timer_bench.sv
module idle_tick_timer_bench;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, tick, ien_wr, ien_wdata, pnd_wr, pnd_wdata, idle_mode, halt_exit;
   logic ien, pnd, irq, wake, startup_done;

   idle_tick_timer u_idle_tick_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .ien_wr       (ien_wr),
      .ien_wdata    (ien_wdata),
      .pnd_wr       (pnd_wr),
      .pnd_wdata    (pnd_wdata),
      .idle_mode    (idle_mode),
      .halt_exit    (halt_exit),
      .ien          (ien),
      .pnd          (pnd),
      .irq          (irq),
      .wake         (wake),
      .startup_done (startup_done)
   );

   int checks = 0;
   int errors = 0;
   bit fin    = 1'b0;

   // Behavioural model: ticks since the last bit-12 change.
   int   m_since = 0;
   bit   synced  = 1'b0;
   bit   m_tog;
   logic m_pnd, m_ien, m_wake, m_done, m_wait;

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pnd = 0; m_ien = 0; m_wake = 0; m_done = 0; m_wait = 0;
      end else begin
         m_tog = 1'b0;
         if (tick) begin
            m_since++;
            if (m_since == 4096) begin
               m_tog   = 1'b1;
               m_since = 0;
            end
         end
         if (!synced) m_tog = 1'b0;
         m_wake = m_tog && idle_mode;
         m_done = m_wait && m_tog;
         m_wait = halt_exit ? 1'b1 : (m_tog ? 1'b0 : m_wait);
         m_pnd  = m_tog ? 1'b1 : (pnd_wr ? pnd_wdata : m_pnd);
         m_ien  = ien_wr ? ien_wdata : m_ien;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !fin) begin
         if (!synced && pnd) begin
            synced  = 1'b1;
            m_since = 0;
            m_pnd   = 1'b1;
         end
         if (synced) begin
            chk("R1,R2,R5 pnd", pnd, m_pnd);
            chk("R4 ien", ien, m_ien);
            chk("R4 irq", irq, m_ien & m_pnd);
            chk("R8 wake", wake, m_wake);
            chk("R7 startup_done", startup_done, m_done);
         end
      end
   end

   task automatic drive(input logic t, input logic iw, input logic iwd,
                        input logic pw, input logic pwd, input logic h);
      tick = t; ien_wr = iw; ien_wdata = iwd;
      pnd_wr = pw; pnd_wdata = pwd; halt_exit = h;
      @(negedge clk);
   endtask

   // Advance until the next ticked edge changes bit 12.
   task automatic brink();
      while (m_since != 4095) drive(1, 0, 0, 0, 0, 0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog expired act=0 exp=1");
         fin = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 0; tick = 0; ien_wr = 0; ien_wdata = 0; pnd_wr = 0;
      pnd_wdata = 0; idle_mode = 0; halt_exit = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      drive(0, 0, 0, 0, 0, 0);
      chk("R3 pnd", pnd, 1'b0);
      chk("R3 ien", ien, 1'b0);
      chk("R3 irq", irq, 1'b0);
      chk("R3 wake", wake, 1'b0);
      chk("R3 startup_done", startup_done, 1'b0);

      while (!synced) drive(1, 0, 0, 0, 0, 0);

      // Irregular tick spacing: period counted in ticks only (R1, R2).
      for (int i = 0; i < 11000; i++) drive(((i % 4) != 3), 0, 0, 0, 0, 0);
      chk("R2 pnd after gaps", pnd, 1'b1);
      begin
         logic exp_p;
         exp_p = (m_since == 4095);
         drive(1, 0, 0, 1, 0, 0);
         chk("R5 clear", pnd, exp_p);
      end

      // Enable and interrupt (R4).
      drive(1, 1, 1, 0, 0, 0);
      chk("R4 enable set", ien, 1'b1);
      brink();
      drive(1, 0, 0, 0, 0, 0);
      chk("R2 pnd on change", pnd, 1'b1);
      chk("R4 irq raised", irq, 1'b1);
      drive(1, 0, 0, 1, 0, 0);
      chk("R4 irq dropped", irq, 1'b0);

      // Clear on the same edge as a change (R6).
      brink();
      drive(1, 0, 0, 1, 0, 0);
      chk("R6 change beats clear", pnd, 1'b1);

      // Software set and clear (R5).
      drive(1, 0, 0, 1, 0, 0);
      chk("R5 cleared", pnd, 1'b0);
      drive(1, 0, 0, 1, 1, 0);
      chk("R5 set by write", pnd, 1'b1);
      drive(1, 1, 0, 1, 0, 0);
      chk("R4 enable cleared", ien, 1'b0);

      // Idle wake with interrupt disabled (R8).
      idle_mode = 1;
      brink();
      chk("R8 no wake early", wake, 1'b0);
      drive(1, 0, 0, 0, 0, 0);
      chk("R8 wake pulse", wake, 1'b1);
      drive(1, 0, 0, 0, 0, 0);
      chk("R8 wake one cycle", wake, 1'b0);
      idle_mode = 0;
      brink();
      drive(1, 0, 0, 0, 0, 0);
      chk("R8 no wake when busy", wake, 1'b0);

      // Start-up delay after halt (R7).
      drive(1, 0, 0, 0, 0, 1);
      brink();
      chk("R7 held low", startup_done, 1'b0);
      drive(1, 0, 0, 0, 0, 0);
      chk("R7 done pulse", startup_done, 1'b1);
      drive(1, 0, 0, 0, 0, 0);
      chk("R7 done one cycle", startup_done, 1'b0);
      brink();
      drive(1, 0, 0, 0, 0, 1);
      chk("R7 request on change waits", startup_done, 1'b0);
      brink();
      drive(1, 0, 0, 0, 0, 0);
      chk("R7 done after next change", startup_done, 1'b1);
      drive(1, 0, 0, 0, 0, 0);

      fin = 1'b1;
      summary();
      $finish;
   end

endmodule